// File: doc/BRIEF.md
# Two-Channel Programmable Fault Manager

This block gathers fault flags for two power channels, together with a few faults shared by both, and decides for each channel whether it may run. Each fault has an enable bit. A disabled fault is ignored completely. An enabled fault sets a sticky status bit. That bit stays set until software pulses the clear strobe. While any status bit that concerns a channel is set, the channel's active-low fault pin is held low.

Four channel faults can each be set to one of two responses:

- **Latched.** The channel stays off until its status is cleared.
- **Auto-restart.** The channel stays off while the condition persists. Once the condition is gone, a restart timer must also run out before the channel turns on again. The timer counts ticks of a prescaled clock. If the fault returns during the countdown, the count starts again from zero.

The open-pin faults and LED undercurrent always latch. Among the shared faults:

- An over-temperature shutdown stops both channels only while it is present.
- A temperature warning only reports.
- A missing oscillator resistor latches both channels off.
- A power-on flag records that the block came out of reset.

Top module: `fault_supervisor`

## Requirements
- R1: An enabled fault sets its status bit on the clock edge that samples it. The bit stays set after the raw flag drops and is cleared only by `status_clr`. If the raw flag is still present in the clear cycle, the bit stays set.
- R2: A fault whose enable bit is 0 sets no status bit, does not pull a fault pin low and does not turn a channel off.
- R3: `flt_n[c]` is low exactly when any status bit of channel c, or any of shared status bits 0 to 2, is set.
- R4: Channel faults 4 to 6 always latch. Faults 0 to 3 latch when their `latch_sel` bit is 1. A latched fault keeps `ch_on[c]` at 0 until the status is cleared while the raw flag is absent.
- R5: Faults 0 to 3 with `latch_sel` bit 0 auto-restart. `ch_on[c]` is 0 while the flag is present. After the flag clears, the channel counts `restart_ticks` prescaler ticks (one tick every PRESCALE cycles) and turns on at the edge after the last tick. With PRESCALE=4 and 3 ticks, this is between 9 and 13 edges after the first edge that samples the flag low.
- R6: If an auto-restart fault reasserts during the countdown, the countdown restarts from zero after the flag clears again.
- R7: Shared bit 0 (thermal shutdown) turns both channels off on the edge that samples it. Both channels return on the edge that samples it low, with no timer.
- R8: Shared bit 1 (thermal warning) sets its status bit and pulls both pins low, but leaves both channels on.
- R9: Shared bit 2 (oscillator resistor open) latches both channels off until its status is cleared.
- R10: `gl_status[3]` (power-on) is 1 after reset and is cleared by `status_clr`. It never pulls a pin low.
- R11: `ch_on[c]` is never 1 unless `run_req[c]` is 1. After reset, all channel status bits are 0 and both pins are high.
- R12: A fault on one channel does not affect the other channel's status, pin or enable.

Channel field encoding, per channel c at bits [c*7 +: 7]:

| Bit | Fault |
|-----|-------|
| 0 | current limit |
| 1 | output overvoltage |
| 2 | output undervoltage |
| 3 | LED overcurrent |
| 4 | LED undercurrent |
| 5 | feedback open |
| 6 | sense open |

`latch_sel` holds 4 bits per channel at [c*4 +: 4]. Each bit maps to channel faults 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | NCH | Per-channel run request |
| ch_flt_raw | input | NCH*7 | Raw channel fault flags |
| ch_flt_en | input | NCH*7 | Channel fault enables |
| latch_sel | input | NCH*4 | Latch (1) or auto-restart (0) for channel faults 0 to 3 |
| gl_flt_raw | input | 3 | Shared faults: thermal shutdown, thermal warning, oscillator resistor open |
| gl_flt_en | input | 3 | Enables for the shared faults |
| restart_ticks | input | NCH*TMR_W | Restart delay per channel, in prescaler ticks |
| status_clr | input | 1 | Clear strobe for all status bits |
| ch_on | output | NCH | Channel enable |
| flt_n | output | NCH | Active-low fault pin per channel |
| ch_status | output | NCH*7 | Sticky channel status |
| gl_status | output | 4 | Sticky shared status; bit 3 is power-on |

## Verification
The hardest case to reach is an auto-restart countdown that is interrupted partway. The stimulus releases the fault and waits until the count has passed its midpoint. It then raises the fault for a single cycle and checks that the channel is still off at a point where an uninterrupted countdown would already have finished. The prescaler's phase is not visible at the ports, so each restart check uses an earliest and a latest edge rather than one exact edge.

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int NCH      = 2,
  parameter int PRESCALE = 4,
  parameter int TMR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       run_req,
  input  logic [NCH*7-1:0]     ch_flt_raw,
  input  logic [NCH*7-1:0]     ch_flt_en,
  input  logic [NCH*4-1:0]     latch_sel,
  input  logic [2:0]           gl_flt_raw,
  input  logic [2:0]           gl_flt_en,
  input  logic [NCH*TMR_W-1:0] restart_ticks,
  input  logic                 status_clr,
  output logic [NCH-1:0]       ch_on,
  output logic [NCH-1:0]       flt_n,
  output logic [NCH*7-1:0]     ch_status,
  output logic [3:0]           gl_status
);
  localparam int CF = 7;
  localparam int NS = 4;
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] pre_q;
  logic          tick;
  logic [2:0]    gl_hit;
  logic [3:0]    gl_q;
  logic          tsd_q;
  logic          gl_pin, gl_stop;

  assign tick = (pre_q == PW'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_q <= '0;
    else        pre_q <= tick ? '0 : pre_q + 1'b1;

  assign gl_hit = gl_flt_raw & gl_flt_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gl_q  <= 4'b1000;
      tsd_q <= 1'b0;
    end else begin
      gl_q[2:0] <= (status_clr ? 3'b000 : gl_q[2:0]) | gl_hit;
      if (status_clr) gl_q[3] <= 1'b0;
      tsd_q <= gl_hit[0];
    end

  assign gl_status = gl_q;
  assign gl_pin    = |gl_q[2:0];
  assign gl_stop   = tsd_q | gl_q[2];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CF-1:0]    hit, st_q, latching;
    logic [TMR_W-1:0] cnt_q, lim;
    logic             hold_q, auto_hit, latch_blk;

    assign hit       = ch_flt_raw[c*CF +: CF] & ch_flt_en[c*CF +: CF];
    assign latching  = {3'b111, latch_sel[c*NS +: NS]};
    assign auto_hit  = |(hit & ~latching);
    assign latch_blk = |(st_q & latching);
    assign lim       = restart_ticks[c*TMR_W +: TMR_W];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) st_q <= '0;
      else        st_q <= (status_clr ? '0 : st_q) | hit;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else if (auto_hit) begin
        hold_q <= 1'b1;
        cnt_q  <= '0;
      end else if (hold_q) begin
        if (cnt_q >= lim) begin
          hold_q <= 1'b0;
          cnt_q  <= '0;
        end else if (tick) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

    assign ch_status[c*CF +: CF] = st_q;
    assign ch_on[c] = run_req[c] & ~latch_blk & ~hold_q & ~gl_stop;
    assign flt_n[c] = ~(|st_q | gl_pin);
  end
endmodule

module fault_supervisor_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   run_req,
  input logic [NCH*7-1:0] ch_flt_raw,
  input logic [NCH*7-1:0] ch_flt_en,
  input logic [2:0]       gl_flt_raw,
  input logic [2:0]       gl_flt_en,
  input logic             status_clr,
  input logic [NCH-1:0]   ch_on,
  input logic [NCH-1:0]   flt_n,
  input logic [NCH*7-1:0] ch_status,
  input logic [3:0]       gl_status
);
  // R11
  on_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_on & ~run_req) == '0);

  // R1
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_clr |=> ((ch_status & $past(ch_status)) == $past(ch_status)));

  // R2
  masked_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ch_status & ~$past(ch_status) & ~$past(ch_flt_raw & ch_flt_en)) == '0));

  // R3
  pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_status == '0 && gl_status[2:0] == 3'b000) |-> (flt_n == '1));

  // R7
  tsd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gl_flt_raw[0] & gl_flt_en[0]) |=> (ch_on == '0));
endmodule

bind fault_supervisor fault_supervisor_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_req(run_req), .ch_flt_raw(ch_flt_raw),
  .ch_flt_en(ch_flt_en), .gl_flt_raw(gl_flt_raw), .gl_flt_en(gl_flt_en),
  .status_clr(status_clr), .ch_on(ch_on), .flt_n(flt_n),
  .ch_status(ch_status), .gl_status(gl_status)
);

// File: tb/fault_supervisor_bench.sv
module fault_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int TMR_W = 8;

  logic             clk = 0;
  logic             rst_n = 0;
  logic [NCH-1:0]   run_req = '1;
  logic [NCH*7-1:0] ch_flt_raw = '0;
  logic [NCH*7-1:0] ch_flt_en = '1;
  logic [NCH*4-1:0] latch_sel = '0;
  logic [2:0]       gl_flt_raw = '0;
  logic [2:0]       gl_flt_en = '1;
  logic [NCH*TMR_W-1:0] restart_ticks = {8'd3, 8'd3};
  logic             status_clr = 0;
  logic [NCH-1:0]   ch_on, flt_n;
  logic [NCH*7-1:0] ch_status;
  logic [3:0]       gl_status;

  int n_chk = 0, n_fail = 0;

  fault_supervisor #(.NCH(NCH), .PRESCALE(4), .TMR_W(TMR_W)) u_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .ch_flt_raw(ch_flt_raw),
    .ch_flt_en(ch_flt_en), .latch_sel(latch_sel), .gl_flt_raw(gl_flt_raw),
    .gl_flt_en(gl_flt_en), .restart_ticks(restart_ticks), .status_clr(status_clr),
    .ch_on(ch_on), .flt_n(flt_n), .ch_status(ch_status), .gl_status(gl_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_pulse();
    status_clr = 1; step(1); status_clr = 0;
  endtask

  task automatic t_reset();
    chk("R11 status", ch_status, 0);
    chk("R11 pins", flt_n, 2'b11);
    chk("R11 on", ch_on, 2'b11);
    chk("R10 por set", gl_status, 4'b1000);
    clr_pulse();
    chk("R10 por cleared", gl_status, 4'b0000);
    chk("R10 pins", flt_n, 2'b11);
  endtask

  task automatic t_mask();
    ch_flt_en[1] = 0;
    ch_flt_raw[1] = 1; step(3);
    chk("R2 status", ch_status, 0);
    chk("R2 pins", flt_n, 2'b11);
    chk("R2 on", ch_on, 2'b11);
    ch_flt_raw[1] = 0; ch_flt_en[1] = 1; step(1);
  endtask

  task automatic t_sticky();
    ch_flt_raw[7+4] = 1; step(1); ch_flt_raw[7+4] = 0;
    chk("R1 set", ch_status, 14'h1 << 11);
    chk("R3 pin low", flt_n, 2'b01);
    chk("R4 off", ch_on, 2'b01);
    chk("R12 other ch", {ch_status[6:0], flt_n[0], ch_on[0]}, 9'b0000000_11);
    step(3);
    chk("R1 sticky", ch_status, 14'h1 << 11);
    chk("R4 still off", ch_on, 2'b01);
    clr_pulse();
    chk("R1 cleared", ch_status, 0);
    chk("R4 back on", ch_on, 2'b11);
    chk("R3 pin high", flt_n, 2'b11);
    ch_flt_raw[5] = 1; step(1);
    clr_pulse();
    chk("R1 set wins", ch_status, 14'h20);
    ch_flt_raw[5] = 0; step(1);
    clr_pulse();
    chk("R1 cleared after drop", ch_status, 0);
    chk("R4 on after drop", ch_on, 2'b11);
  endtask

  task automatic t_latch_sel();
    latch_sel[1] = 1;
    ch_flt_raw[1] = 1; step(1); ch_flt_raw[1] = 0;
    step(40);
    chk("R4 latched OV off", ch_on, 2'b10);
    clr_pulse();
    chk("R4 latched OV released", ch_on, 2'b11);
    latch_sel[1] = 0;
  endtask

  task automatic t_auto();
    ch_flt_raw[0] = 1; step(5);
    chk("R5 off while present", ch_on, 2'b10);
    ch_flt_raw[0] = 0; step(1);
    step(6);
    chk("R5 still counting", ch_on, 2'b10);
    step(10);
    chk("R5 restarted", ch_on, 2'b11);
    chk("R3 pin held by status", flt_n, 2'b10);
    clr_pulse();
    chk("R3 pin released", flt_n, 2'b11);
  endtask

  task automatic t_restart();
    ch_flt_raw[7+2] = 1; step(2);
    ch_flt_raw[7+2] = 0; step(1);
    step(6);
    ch_flt_raw[7+2] = 1; step(1);
    ch_flt_raw[7+2] = 0; step(1);
    step(6);
    chk("R6 countdown restarted", ch_on, 2'b01);
    step(10);
    chk("R6 eventually on", ch_on, 2'b11);
    clr_pulse();
  endtask

  task automatic t_tsd();
    gl_flt_raw[0] = 1; step(1);
    chk("R7 both off", ch_on, 2'b00);
    chk("R7 pins low", flt_n, 2'b00);
    step(20);
    chk("R7 still off", ch_on, 2'b00);
    gl_flt_raw[0] = 0; step(1);
    chk("R7 on at once", ch_on, 2'b11);
    chk("R7 status kept", gl_status, 4'b0001);
    clr_pulse();
  endtask

  task automatic t_tw();
    gl_flt_raw[1] = 1; step(1);
    chk("R8 on", ch_on, 2'b11);
    chk("R8 pins low", flt_n, 2'b00);
    chk("R8 status", gl_status, 4'b0010);
    gl_flt_raw[1] = 0; step(1);
    clr_pulse();
    chk("R8 pins released", flt_n, 2'b11);
  endtask

  task automatic t_rt();
    gl_flt_raw[2] = 1; step(1); gl_flt_raw[2] = 0;
    step(10);
    chk("R9 latched off", ch_on, 2'b00);
    clr_pulse();
    chk("R9 released", ch_on, 2'b11);
  endtask

  task automatic t_run();
    run_req = 2'b01; step(1);
    chk("R11 run gating", ch_on, 2'b01);
    run_req = 2'b11; step(1);
  endtask

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    t_reset();
    t_mask();
    t_sticky();
    t_latch_sel();
    t_auto();
    t_restart();
    t_tsd();
    t_tw();
    t_rt();
    t_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule